// File: doc/BRIEF.md
# Compact 8-bit I/O Processor Core

This block is a small processor core for polled peripheral work. It executes fixed 16-bit instruction words fetched from an external program ROM, addressed by a 12-bit program counter. Its data path is eight bits wide, with a bank of eight general registers and a single zero flag. Every instruction takes exactly four clocks: fetch, decode with operand read, execute or I/O setup, and retire. Retire writes the result back, updates the flag, releases the strobes and moves the program counter.

Peripherals sit in a separate 256-location space. The core drives an 8-bit port address and 8-bit write data, and takes in 8-bit read data. A read strobe or a write strobe stays high for two clocks per access. The ROM is read asynchronously: the core presents the address and samples the word at the end of the fetch clock.

Top module: `pio_core`

## Requirements
- R1: An instruction word carries its opcode in bits 15:12, a register select in bits 11:8 and an immediate or port address in bits 7:0. The opcodes are 0x1 load immediate, 0x2 add immediate, 0x3 AND immediate, 0x4 OR immediate, 0x5 XOR immediate, 0x6 port read, 0x7 port write, 0x8 jump and 0x9 branch if zero. Any other opcode does nothing but advance the program counter.
- R2: While reset is high, and on the first clock after it falls, the ROM address, port address and both strobes are zero. Reset also clears every register and the zero flag.
- R3: Each instruction occupies exactly four clocks. The ROM address changes only at the end of the fourth clock, and it increments from 4095 to 0.
- R4: An immediate ALU operation writes its 8-bit result to the selected register. Addition wraps modulo 256. The zero flag is set when that result is zero and cleared otherwise.
- R5: A port read raises the read strobe for two clocks, with the port address taken from bits 7:0. The read data present in the second strobe clock is stored in the selected register, and the zero flag is updated from it.
- R6: A port write raises the write strobe for exactly two clocks. The port address and the data of the selected register are stable across both clocks. The two strobes are never high together.
- R7: A jump loads the program counter with the 12-bit target formed from bits 11:0 of the instruction.
- R8: A branch if zero jumps to the bits 11:0 target when the zero flag is set, and otherwise falls through to the next instruction.
- R9: Register selects 8 to 15 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| romAddr | output | 12 | Program ROM word address (program counter) |
| romData | input | 16 | Instruction word at romAddr |
| ioAddr | output | 8 | Peripheral port address |
| ioWrData | output | 8 | Peripheral write data |
| ioRdData | input | 8 | Peripheral read data |
| ioRd | output | 1 | Read strobe, high for two clocks per read |
| ioWr | output | 1 | Write strobe, high for two clocks per write |

## Verification
The hardest case to reach from the ports is the wrap of the program counter from 4095 to 0. The program must first jump to the last ROM word and then run past it. The bench places a port write at address 4095 and checks that the very next write is the first one of the program. The bench also uses port writes to expose register contents, including registers never written since reset and a write to an unimplemented select. Branches take the zero flag as set both by a port read and by an XOR.

// File: rtl/pio_pkg.sv
`timescale 1ns/1ps
package pio_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_NOP  = 4'h0,
    OP_LDI  = 4'h1,
    OP_ADDI = 4'h2,
    OP_ANDI = 4'h3,
    OP_ORI  = 4'h4,
    OP_XORI = 4'h5,
    OP_IORD = 4'h6,
    OP_IOWR = 4'h7,
    OP_JMP  = 4'h8,
    OP_BEZ  = 4'h9
  } opcode_e;

  typedef enum logic [1:0] {
    PH_FETCH  = 2'd0,
    PH_DECODE = 2'd1,
    PH_EXEC   = 2'd2,
    PH_RETIRE = 2'd3
  } phase_e;

  typedef struct packed {
    logic loadIr;
    logic loadOperand;
    logic loadIoSetup;
    logic execAlu;
    logic regWrite;
    logic selIoData;
    logic zeroWrite;
    logic pcJump;
    logic pcStep;
  } ctrl_t;

endpackage

// File: rtl/pio_regfile.sv
`timescale 1ns/1ps
module pio_regfile #(
  parameter int NREGS  = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DATA_W-1:0] rdData
);

  logic [NREGS-1:0][DATA_W-1:0] regs;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[i] <= '0;
      end else if (wrEn && (wrSel == SEL_W'(i))) begin
        regs[i] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (rdSel == SEL_W'(i)) rdData = regs[i];
    end
  end

  AST_HIGH_SEL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wrEn && (wrSel >= SEL_W'(NREGS))) |=> $stable(regs)); // R9

endmodule

// File: rtl/pio_control.sv
`timescale 1ns/1ps
module pio_control
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  input  logic             zeroFlag,
  output ctrl_t            ctrl,
  output logic             ioRd,
  output logic             ioWr
);

  phase_e phase;
  logic isAlu, isRead, isWrite, takeJump;
  logic rdSet, wrSet, strobeClr;

  always_comb begin
    isAlu   = (opcode == OP_LDI) || (opcode == OP_ADDI) || (opcode == OP_ANDI)
           || (opcode == OP_ORI) || (opcode == OP_XORI);
    isRead  = (opcode == OP_IORD);
    isWrite = (opcode == OP_IOWR);
    takeJump = (opcode == OP_JMP) || ((opcode == OP_BEZ) && zeroFlag);
  end

  always_ff @(posedge clk) begin
    if (rst) phase <= PH_FETCH;
    else     phase <= phase_e'(phase + 2'd1);
  end

  always_comb begin
    ctrl      = '0;
    rdSet     = 1'b0;
    wrSet     = 1'b0;
    strobeClr = 1'b0;
    unique case (phase)
      PH_FETCH:  ctrl.loadIr = 1'b1;
      PH_DECODE: begin
        ctrl.loadOperand = 1'b1;
        ctrl.loadIoSetup = isRead || isWrite;
        rdSet = isRead;
        wrSet = isWrite;
      end
      PH_EXEC:   ctrl.execAlu = isAlu;
      PH_RETIRE: begin
        ctrl.regWrite  = isAlu || isRead;
        ctrl.selIoData = isRead;
        ctrl.zeroWrite = isAlu || isRead;
        ctrl.pcJump    = takeJump;
        ctrl.pcStep    = !takeJump;
        strobeClr      = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ioRd <= 1'b0;
      ioWr <= 1'b0;
    end else begin
      if (rdSet) ioRd <= 1'b1;
      else if (strobeClr) ioRd <= 1'b0;
      if (wrSet) ioWr <= 1'b1;
      else if (strobeClr) ioWr <= 1'b0;
    end
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ioRd && ioWr)); // R6
  AST_RD_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(ioRd) |=> ioRd); // R5
  AST_RD_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ioRd && $past(ioRd)) |=> !ioRd); // R5
  AST_WR_TWO_CLK: assert property (@(posedge clk) disable iff (rst)
    $rose(ioWr) |=> ioWr); // R6
  AST_WR_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (ioWr && $past(ioWr)) |=> !ioWr); // R6
  AST_STROBE_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
    ($rose(ioRd) || $rose(ioWr)) |-> (phase == PH_EXEC)); // R3

endmodule

// File: rtl/pio_datapath.sv
`timescale 1ns/1ps
module pio_datapath
  import pio_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int INSTR_W = OPC_W + SEL_W + DATA_W,
  localparam int PC_W    = SEL_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  input  ctrl_t              ctrl,
  input  logic [INSTR_W-1:0] romData,
  output logic [PC_W-1:0]    romAddr,
  input  logic [DATA_W-1:0]  ioRdData,
  output logic [DATA_W-1:0]  ioAddr,
  output logic [DATA_W-1:0]  ioWrData,
  output logic [OPC_W-1:0]   opcode,
  output logic               zeroFlag
);

  logic [INSTR_W-1:0] irQ;
  logic [PC_W-1:0]    pcQ;
  logic [DATA_W-1:0]  operandQ, resultQ, ioAddrQ, ioWrDataQ;
  logic [DATA_W-1:0]  aluOut, rfRdData, wbData;
  logic               zeroQ;
  logic [SEL_W-1:0]   regSel;
  logic [DATA_W-1:0]  immVal;

  assign opcode = irQ[INSTR_W-1 -: OPC_W];
  assign regSel = irQ[DATA_W +: SEL_W];
  assign immVal = irQ[DATA_W-1:0];

  pio_regfile #(.NREGS(NREGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_rf (
    .clk   (clk),
    .rst   (rst),
    .wrEn  (ctrl.regWrite),
    .wrSel (regSel),
    .wrData(wbData),
    .rdSel (regSel),
    .rdData(rfRdData)
  );

  always_comb begin
    unique case (opcode)
      OP_LDI:  aluOut = immVal;
      OP_ADDI: aluOut = operandQ + immVal;
      OP_ANDI: aluOut = operandQ & immVal;
      OP_ORI:  aluOut = operandQ | immVal;
      OP_XORI: aluOut = operandQ ^ immVal;
      default: aluOut = operandQ;
    endcase
  end

  assign wbData = ctrl.selIoData ? ioRdData : resultQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      irQ       <= '0;
      pcQ       <= '0;
      operandQ  <= '0;
      resultQ   <= '0;
      ioAddrQ   <= '0;
      ioWrDataQ <= '0;
      zeroQ     <= 1'b0;
    end else begin
      if (ctrl.loadIr)      irQ <= romData;
      if (ctrl.loadOperand) operandQ <= rfRdData;
      if (ctrl.loadIoSetup) begin
        ioAddrQ   <= immVal;
        ioWrDataQ <= rfRdData;
      end
      if (ctrl.execAlu)     resultQ <= aluOut;
      if (ctrl.zeroWrite)   zeroQ <= (wbData == '0);
      if (ctrl.pcJump)      pcQ <= irQ[PC_W-1:0];
      else if (ctrl.pcStep) pcQ <= pcQ + 1'b1;
    end
  end

  assign romAddr  = pcQ;
  assign ioAddr   = ioAddrQ;
  assign ioWrData = ioWrDataQ;
  assign zeroFlag = zeroQ;

  AST_PC_ONLY_AT_RETIRE: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.pcStep || ctrl.pcJump) |=> $stable(romAddr)); // R3
  AST_IR_HELD: assert property (@(posedge clk) disable iff (rst)
    !ctrl.loadIr |=> $stable(opcode)); // R1
  AST_ZERO_ONLY_ON_WB: assert property (@(posedge clk) disable iff (rst)
    !ctrl.zeroWrite |=> $stable(zeroFlag)); // R4

endmodule

// File: rtl/pio_core.sv
`timescale 1ns/1ps
module pio_core
  import pio_pkg::*;
#(
  parameter int NREGS  = 8,
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  localparam int INSTR_W = OPC_W + SEL_W + DATA_W,
  localparam int PC_W    = SEL_W + DATA_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PC_W-1:0]    romAddr,
  input  logic [INSTR_W-1:0] romData,
  output logic [DATA_W-1:0]  ioAddr,
  output logic [DATA_W-1:0]  ioWrData,
  input  logic [DATA_W-1:0]  ioRdData,
  output logic               ioRd,
  output logic               ioWr
);

  ctrl_t            ctrl;
  logic [OPC_W-1:0] opcode;
  logic             zeroFlag;

  pio_control u_ctl (
    .clk     (clk),
    .rst     (rst),
    .opcode  (opcode),
    .zeroFlag(zeroFlag),
    .ctrl    (ctrl),
    .ioRd    (ioRd),
    .ioWr    (ioWr)
  );

  pio_datapath #(.NREGS(NREGS), .DATA_W(DATA_W), .SEL_W(SEL_W)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .ctrl    (ctrl),
    .romData (romData),
    .romAddr (romAddr),
    .ioRdData(ioRdData),
    .ioAddr  (ioAddr),
    .ioWrData(ioWrData),
    .opcode  (opcode),
    .zeroFlag(zeroFlag)
  );

  AST_WR_BUS_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ioWr && $past(ioWr)) |-> ($stable(ioAddr) && $stable(ioWrData))); // R6
  AST_RD_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
    (ioRd && $past(ioRd)) |-> $stable(ioAddr)); // R5
  AST_ROM_STEADY_DURING_IO: assert property (@(posedge clk) disable iff (rst)
    (ioRd || ioWr) |=> $stable(romAddr) || !(ioRd || ioWr)); // R3

endmodule

// File: tb/pio_core_test.sv
`timescale 1ns/1ps
module pio_core_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] romAddr;
  logic [15:0] romData;
  logic [7:0]  ioAddr, ioWrData, ioRdData;
  logic        ioRd, ioWr;

  int checks = 0;
  int fails  = 0;
  int cycle  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pio_core uut (
    .clk(clk), .rst(rst), .romAddr(romAddr), .romData(romData),
    .ioAddr(ioAddr), .ioWrData(ioWrData), .ioRdData(ioRdData),
    .ioRd(ioRd), .ioWr(ioWr)
  );

  // Program: opcode[15:12] select[11:8] imm/addr[7:0] (R1)
  function automatic logic [15:0] romWord(input logic [11:0] a);
    case (a)
      12'd0:    return 16'h113C; // LDI r1,3C
      12'd1:    return 16'h7110; // OUT r1 -> 10
      12'd2:    return 16'h21F0; // ADDI r1,F0 -> 2C
      12'd3:    return 16'h7111;
      12'd4:    return 16'h310F; // ANDI -> 0C
      12'd5:    return 16'h41A0; // ORI  -> AC
      12'd6:    return 16'h51FF; // XORI -> 53
      12'd7:    return 16'h7112;
      12'd8:    return 16'h6240; // IN r2 <- 40
      12'd9:    return 16'h7213;
      12'd10:   return 16'h1977; // LDI r9 (ignored)
      12'd11:   return 16'h7914;
      12'd12:   return 16'h5153; // XORI -> 00, Z=1
      12'd13:   return 16'h9010; // BEZ 010 taken
      12'd14:   return 16'h71EE;
      12'd16:   return 16'h7115;
      12'd17:   return 16'h1301; // LDI r3,01 Z=0
      12'd18:   return 16'h9020; // BEZ not taken
      12'd19:   return 16'h7316;
      12'd20:   return 16'h8100; // JMP 100
      12'd21:   return 16'h73EE;
      12'd256:  return 16'h64A5; // IN r4 <- A5
      12'd257:  return 16'h7417;
      12'd258:  return 16'h655A; // IN r5 <- 5A gives 00, Z=1
      12'd259:  return 16'h9200; // BEZ 200 taken
      12'd260:  return 16'h71EE;
      12'd512:  return 16'h7018; // r0 untouched
      12'd513:  return 16'h77FF; // r7 untouched, port FF
      12'd514:  return 16'h8FFF; // JMP FFF
      12'd4095: return 16'h7319;
      default:  return 16'h0000;
    endcase
  endfunction

  assign romData  = romWord(romAddr);
  assign ioRdData = ioRd ? (ioAddr ^ 8'h5A) : 8'h00;

  localparam int NVEC = 12;
  localparam logic [15:0] EXP_WR [NVEC] = '{
    16'h103C, 16'h112C, 16'h1253, 16'h131A, 16'h1400, 16'h1500,
    16'h1601, 16'h17FF, 16'h1800, 16'hFF00, 16'h1901, 16'h103C };

  function automatic string vecReq(input int i);
    case (i)
      0: return "R1"; 1: return "R4"; 2: return "R4"; 3: return "R5";
      4: return "R9"; 5: return "R8"; 6: return "R8"; 7: return "R7";
      8: return "R2"; 9: return "R2"; 10: return "R7";
      default: return "R3";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) cycle++;

  // Read strobe monitor
  localparam logic [7:0] EXP_RD [3] = '{8'h40, 8'hA5, 8'h5A};
  int rdIdx = 0;
  int rdRun = 0;
  always @(negedge clk) begin
    if (rst) rdRun = 0;
    else if (ioRd) begin
      if (rdRun == 0 && rdIdx < 3) begin
        check(ioAddr == EXP_RD[rdIdx], "R5", "read port address",
              {8'h0, ioAddr}, {8'h0, EXP_RD[rdIdx]});
        rdIdx++;
      end
      rdRun++;
    end else if (rdRun != 0) begin
      check(rdRun == 2, "R5", "read strobe width", 16'(rdRun), 16'd2);
      rdRun = 0;
    end
  end

  // Watchdog
  initial begin
    while (!done && cycle < 20000) @(negedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected <20000 cycles", cycle);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic expectWrite(input logic [15:0] exp, input string req,
                             output int riseCycle);
    do @(negedge clk); while (!ioWr);
    riseCycle = cycle;
    check({ioAddr, ioWrData} == exp, req, "write port/data",
          {ioAddr, ioWrData}, exp);
    check(!ioRd, "R6", "strobes exclusive", {15'h0, ioRd}, 16'h0);
    @(negedge clk);
    check(ioWr && ({ioAddr, ioWrData} == exp), "R6", "write second clock",
          {ioAddr, ioWrData}, exp);
    @(negedge clk);
    check(!ioWr, "R6", "write strobe released", {15'h0, ioWr}, 16'h0);
  endtask

  initial begin
    int prevRise = 0;
    int rise = 0;
    repeat (3) @(negedge clk);
    check(romAddr == 12'h0 && !ioRd && !ioWr && ioAddr == 8'h0, "R2",
          "state in reset", {romAddr, ioRd, ioWr, 2'b0}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    check(romAddr == 12'h0 && ioAddr == 8'h0, "R2", "first clock after reset",
          {4'h0, romAddr}, 16'h0);
    repeat (2) @(negedge clk);
    check(romAddr == 12'h0, "R3", "pc held through cycle three",
          {4'h0, romAddr}, 16'h0);
    @(negedge clk);
    check(romAddr == 12'h1, "R3", "pc steps after four clocks",
          {4'h0, romAddr}, 16'h1);

    for (int i = 0; i < NVEC; i++) begin
      expectWrite(EXP_WR[i], vecReq(i), rise);
      if (i == 9)
        check(rise - prevRise == 4, "R3", "back-to-back writes four clocks apart",
              16'(rise - prevRise), 16'd4);
      prevRise = rise;
    end
    check(rdIdx == 3, "R5", "number of port reads", 16'(rdIdx), 16'd3);

    // Reset in the middle of a run
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(romAddr == 12'h0 && !ioRd && !ioWr && ioAddr == 8'h0, "R2",
          "mid-run reset", {romAddr, ioRd, ioWr, 2'b0}, 16'h0);
    rst = 1'b0;
    expectWrite(16'h103C, "R2", rise);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule